// File: doc/BRIEF.md
# Source-Learning Address Lookup Engine

This block maps station MAC addresses to the ports of an 8-port switch. Each received frame produces a single lookup request that carries its destination MAC, its source MAC, the ingress port and the identifier of the device the frame came from. In one pass the engine records the sender's location and resolves the destination into a forwarding port mask. It also raises a flag when the frame has to be flooded.

Entries live in an on-chip array. The array is indexed by a CRC hash of the MAC, and its depth is a parameter. After reset the engine sweeps every entry to invalid, and it holds a busy output high until the sweep is done. Requests and responses each use a valid/ready handshake. A response is ready a fixed two clock edges after its request is accepted, and the engine holds one frame at a time.

Top module: `addr_lookup_engine`

## Requirements
- R1: After reset, `busy` is high and `req_ready` is low while every table entry is cleared, one entry per cycle (about DEPTH cycles). No request offered during that time is accepted. Once the sweep ends, no address is known.
- R2: An entry's index is the low log2(DEPTH) bits of a CRC-8 remainder over the 48-bit MAC. The CRC uses polynomial x^8+x^2+x+1 (0x07) and a zero initial value, and it takes the MAC bits most significant bit first (bit 47 first). Each index holds one entry.
- R3: A unicast source MAC that is not present is written at its index, together with the ingress port and the device identifier.
- R4: A unicast destination found in the table gives a mask with only bit p set, where p is the learned port and mask bit i stands for port i. In that case `rsp_flood` is 0 and `rsp_dev` returns the stored device identifier.
- R5: A unicast destination not found in the table gives a mask with every bit set except the ingress port's bit. In that case `rsp_flood` is 1 and `rsp_dev` is 0.
- R6: A destination whose bit 40 (the least significant bit of the first octet) is 1 is multicast or broadcast. Such a frame is always flooded as in R5, whatever the table holds.
- R7: A source MAC with bit 40 set is never written into the table.
- R8: A known source seen on a different port or device overwrites its entry with the new location.
- R9: A destination learned on the ingress port itself gives an all-zero mask with `rsp_flood` 0.
- R10: A source whose index already holds a different MAC replaces that entry. A lookup sees the table as it stood before the current frame's own learning.
- R11: `rsp_valid` rises on the second clock edge after the accept edge. While `rsp_ready` is low, the response fields stay stable. `req_ready` stays low from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Engine can take a request |
| req_dst | input | 48 | Destination MAC |
| req_src | input | 48 | Source MAC |
| req_port | input | 3 | Ingress port |
| req_dev | input | DEV_W (2) | Device identifier of the ingress side |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_mask | output | 8 | Forwarding port mask, bit i = port i |
| rsp_flood | output | 1 | Frame is flooded |
| rsp_dev | output | DEV_W (2) | Device of the learned destination, 0 if not found |
| busy | output | 1 | Reset-time table clear in progress |

## Verification
The lookup is tried with several kinds of destination: one never seen, one learned on another port, one learned on the ingress port, a broadcast address, and a hash twin of a learned station. Together these separate flooding, directed forwarding, filtering and tag comparison. Source patterns include a station that moves, a multicast sender that shares an index with a learned station, and a frame whose destination equals its own new source. These show whether learning overwrites, skips, or takes effect too early. A stalled response consumer and a request held during the reset sweep check the handshake at both of its edges.

// File: rtl/ale_pkg.sv
package ale_pkg;
  localparam int MAC_W     = 48;
  localparam int MCAST_BIT = 40;
  localparam int CRC_W     = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_RESP = 2'd2
  } ale_state_e;
endpackage

// File: rtl/ale_hash.sv
module ale_hash
  import ale_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  mac_t             mac,
  output logic [IDX_W-1:0] idx
);
  logic [CRC_W-1:0] crc;
  logic             fb;

  always_comb begin
    crc = '0;
    fb  = 1'b0;
    for (int b = MAC_W - 1; b >= 0; b--) begin
      fb  = crc[CRC_W-1] ^ mac[b];
      crc = {crc[CRC_W-2:0], 1'b0};
      if (fb) crc = crc ^ CRC_POLY;
    end
    idx = crc[IDX_W-1:0];
  end
endmodule

// File: rtl/ale_table.sv
module ale_table
  import ale_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PORT_W = 3,
  parameter int DEV_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_vld,
  output mac_t              rd_a_mac,
  output logic [PORT_W-1:0] rd_a_port,
  output logic [DEV_W-1:0]  rd_a_dev,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_vld,
  output mac_t              rd_b_mac,
  output logic [PORT_W-1:0] rd_b_port,
  output logic [DEV_W-1:0]  rd_b_dev,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  mac_t              wr_mac,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [DEV_W-1:0]  wr_dev,
  output logic              clr_busy
);
  logic              vld_q  [DEPTH];
  mac_t              mac_q  [DEPTH];
  logic [PORT_W-1:0] port_q [DEPTH];
  logic [DEV_W-1:0]  dev_q  [DEPTH];

  logic             clr_q, clr_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  // clear sweep next state
  always_comb begin
    clr_d = clr_q;
    cnt_d = cnt_q;
    if (clr_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == IDX_W'(DEPTH - 1)) clr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      clr_q <= clr_d;
      cnt_q <= cnt_d;
    end
  end

  assign clr_busy = clr_q;

  // storage: valid swept by clear, payload written only on learning
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (clr_q && (cnt_q == IDX_W'(e))) begin
        vld_q[e] <= 1'b0;
      end else if (!clr_q && wr_en && (wr_idx == IDX_W'(e))) begin
        vld_q[e] <= 1'b1;
      end
      if (!clr_q && wr_en && (wr_idx == IDX_W'(e))) begin
        mac_q[e]  <= wr_mac;
        port_q[e] <= wr_port;
        dev_q[e]  <= wr_dev;
      end
    end
  end

  assign rd_a_vld  = vld_q[rd_a_idx];
  assign rd_a_mac  = mac_q[rd_a_idx];
  assign rd_a_port = port_q[rd_a_idx];
  assign rd_a_dev  = dev_q[rd_a_idx];
  assign rd_b_vld  = vld_q[rd_b_idx];
  assign rd_b_mac  = mac_q[rd_b_idx];
  assign rd_b_port = port_q[rd_b_idx];
  assign rd_b_dev  = dev_q[rd_b_idx];

  // R1: nothing is learned while the sweep runs
  assert_no_learn_in_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !wr_en);

  // R1: the sweep only ends after visiting the last index
  assert_full_sweep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && $past(clr_q)) |-> ($past(cnt_q) == IDX_W'(DEPTH - 1)));
endmodule

// File: rtl/ale_decide.sv
module ale_decide
  import ale_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DEV_W     = 2,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  mac_t                 dst_mac,
  input  mac_t                 src_mac,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [DEV_W-1:0]     in_dev,
  input  logic                 dst_vld,
  input  mac_t                 dst_tag,
  input  logic [PORT_W-1:0]    dst_port,
  input  logic [DEV_W-1:0]     dst_dev,
  input  logic                 src_vld,
  input  mac_t                 src_tag,
  input  logic [PORT_W-1:0]    src_port,
  input  logic [DEV_W-1:0]     src_dev,
  output logic [NUM_PORTS-1:0] fwd_mask,
  output logic                 fwd_flood,
  output logic [DEV_W-1:0]     fwd_dev,
  output logic                 learn
);
  logic                 dst_multi, dst_hit, src_same;
  logic [NUM_PORTS-1:0] in_bit, out_bit;

  always_comb begin
    dst_multi = dst_mac[MCAST_BIT];
    dst_hit   = !dst_multi && dst_vld && (dst_tag == dst_mac);
    in_bit    = '0;
    out_bit   = '0;
    in_bit[in_port]   = 1'b1;
    out_bit[dst_port] = 1'b1;

    if (!dst_hit) begin
      fwd_flood = 1'b1;
      fwd_mask  = ~in_bit;
      fwd_dev   = '0;
    end else begin
      fwd_flood = 1'b0;
      fwd_dev   = dst_dev;
      fwd_mask  = (dst_port == in_port) ? '0 : out_bit;
    end

    src_same = src_vld && (src_tag == src_mac) &&
               (src_port == in_port) && (src_dev == in_dev);
    learn    = !src_mac[MCAST_BIT] && !src_same;
  end
endmodule

// File: rtl/addr_lookup_engine.sv
module addr_lookup_engine
  import ale_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DEPTH     = 64,
  parameter int DEV_W     = 2,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [47:0]          req_dst,
  input  logic [47:0]          req_src,
  input  logic [PORT_W-1:0]    req_port,
  input  logic [DEV_W-1:0]     req_dev,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [NUM_PORTS-1:0] rsp_mask,
  output logic                 rsp_flood,
  output logic [DEV_W-1:0]     rsp_dev,
  output logic                 busy
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  ale_state_e st_q, st_d;
  logic       clr_busy, accept, ld_rsp;

  // captured request
  mac_t              s1_dst, s1_src;
  logic [PORT_W-1:0] s1_port;
  logic [DEV_W-1:0]  s1_dev;

  // hashing, one per looked-up address
  mac_t             hmac [2];
  logic [IDX_W-1:0] hidx [2];
  assign hmac[0] = s1_dst;
  assign hmac[1] = s1_src;

  for (genvar g = 0; g < 2; g++) begin : g_hash
    ale_hash #(.IDX_W(IDX_W)) u_hash (.mac(hmac[g]), .idx(hidx[g]));
  end

  logic              d_vld, s_vld;
  mac_t              d_tag, s_tag;
  logic [PORT_W-1:0] d_port, s_port;
  logic [DEV_W-1:0]  d_dev, s_dev;
  logic              learn, wr_en;

  logic [NUM_PORTS-1:0] fwd_mask;
  logic                 fwd_flood;
  logic [DEV_W-1:0]     fwd_dev;

  ale_table #(.DEPTH(DEPTH), .PORT_W(PORT_W), .DEV_W(DEV_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rd_a_idx (hidx[0]),
    .rd_a_vld (d_vld),
    .rd_a_mac (d_tag),
    .rd_a_port(d_port),
    .rd_a_dev (d_dev),
    .rd_b_idx (hidx[1]),
    .rd_b_vld (s_vld),
    .rd_b_mac (s_tag),
    .rd_b_port(s_port),
    .rd_b_dev (s_dev),
    .wr_en    (wr_en),
    .wr_idx   (hidx[1]),
    .wr_mac   (s1_src),
    .wr_port  (s1_port),
    .wr_dev   (s1_dev),
    .clr_busy (clr_busy)
  );

  ale_decide #(.NUM_PORTS(NUM_PORTS), .DEV_W(DEV_W)) u_decide (
    .dst_mac  (s1_dst),
    .src_mac  (s1_src),
    .in_port  (s1_port),
    .in_dev   (s1_dev),
    .dst_vld  (d_vld),
    .dst_tag  (d_tag),
    .dst_port (d_port),
    .dst_dev  (d_dev),
    .src_vld  (s_vld),
    .src_tag  (s_tag),
    .src_port (s_port),
    .src_dev  (s_dev),
    .fwd_mask (fwd_mask),
    .fwd_flood(fwd_flood),
    .fwd_dev  (fwd_dev),
    .learn    (learn)
  );

  assign busy      = clr_busy;
  assign req_ready = (st_q == ST_IDLE) && !clr_busy;
  assign accept    = req_valid && req_ready;
  assign ld_rsp    = (st_q == ST_LOOK);
  assign wr_en     = ld_rsp && learn;
  assign rsp_valid = (st_q == ST_RESP);

  // control next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)    st_d = ST_LOOK;
      ST_LOOK:                st_d = ST_RESP;
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      s1_dst  <= req_dst;
      s1_src  <= req_src;
      s1_port <= req_port;
      s1_dev  <= req_dev;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_rsp) begin
      rsp_mask  <= fwd_mask;
      rsp_flood <= fwd_flood;
      rsp_dev   <= fwd_dev;
    end
  end

  // R1: requests are refused during the clear sweep
  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !req_ready);

  // R11: fixed two-edge latency
  assert_latency_gap_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> !rsp_valid);
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> ##1 rsp_valid);

  // R11: stalled response holds
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask) &&
                                   $stable(rsp_flood) && $stable(rsp_dev)));

  // R11: single frame in flight
  assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> !req_ready);

  // R5 / R9: never send back out of the ingress port
  assert_no_echo_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> !rsp_mask[s1_port]);

  // R4: directed frames go to at most one port
  assert_directed_single_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && !rsp_flood) |-> ($countones(rsp_mask) <= 1));

  // R6: group destinations are flooded
  assert_group_floods_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && s1_dst[MCAST_BIT]) |-> rsp_flood);
endmodule

// File: tb/sim_addr_lookup_engine.sv
module sim_addr_lookup_engine;
  localparam int NP    = 8;
  localparam int DEPTH = 64;
  localparam int DW    = 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_flood, busy;
  logic [47:0] req_dst, req_src;
  logic [2:0]  req_port;
  logic [DW-1:0] req_dev, rsp_dev;
  logic [NP-1:0] rsp_mask;

  int checks = 0;
  int errors = 0;

  addr_lookup_engine #(.NUM_PORTS(NP), .DEPTH(DEPTH), .DEV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dst(req_dst), .req_src(req_src), .req_port(req_port), .req_dev(req_dev),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_mask(rsp_mask), .rsp_flood(rsp_flood), .rsp_dev(rsp_dev),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference table
  bit          m_v    [DEPTH];
  logic [47:0] m_mac  [DEPTH];
  int          m_port [DEPTH];
  int          m_dev  [DEPTH];

  function automatic int ref_idx(logic [47:0] m);
    int c = 0;
    for (int i = 47; i >= 0; i--) begin
      int fb;
      fb = ((c >> 7) & 1) ^ int'(m[i]);
      c  = (c << 1) & 255;
      if (fb != 0) c = c ^ 7;
    end
    return c % DEPTH;
  endfunction

  task automatic chk(string rq, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one frame: compute expectation from model, run handshake, compare
  task automatic frame(logic [47:0] d, logic [47:0] s, int p, int dv, bit stall, string rq);
    int di, si, emask, eflood, edev;
    bit hit;
    di  = ref_idx(d);
    hit = !d[40] && m_v[di] && (m_mac[di] == d);
    if (!hit) begin
      emask = 8'hFF & ~(1 << p); eflood = 1; edev = 0;
    end else begin
      eflood = 0; edev = m_dev[di];
      emask  = (m_port[di] == p) ? 0 : (1 << m_port[di]);
    end
    if (!s[40]) begin
      si = ref_idx(s);
      m_v[si] = 1'b1; m_mac[si] = s; m_port[si] = p; m_dev[si] = dv;
    end

    @(negedge clk);
    req_dst = d; req_src = s; req_port = 3'(p); req_dev = DW'(dv);
    req_valid = 1'b1;
    rsp_ready = !stall;
    chk("R11", "req_ready idle", longint'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "rsp_valid one edge after accept", longint'(rsp_valid), 0);
    chk("R11", "req_ready in flight", longint'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "rsp_valid two edges after accept", longint'(rsp_valid), 1);
    chk(rq, "mask", longint'(rsp_mask), emask);
    chk(rq, "flood", longint'(rsp_flood), eflood);
    chk(rq, "dev", longint'(rsp_dev), edev);
    if (stall) begin
      repeat (3) @(negedge clk);
      chk("R11", "held valid", longint'(rsp_valid), 1);
      chk("R11", "held mask", longint'(rsp_mask), emask);
      chk("R11", "held ready low", longint'(req_ready), 0);
      rsp_ready = 1'b1;
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    chk("R11", "response taken", longint'(rsp_valid), 0);
  endtask

  // find a unicast MAC sharing the index of m, different from m
  function automatic logic [47:0] twin(logic [47:0] m, logic [47:0] start);
    logic [47:0] t = start;
    for (int k = 0; k < 4096; k++) begin
      if (ref_idx(t) == ref_idx(m) && t != m && !t[40]) return t;
      t = t + 48'd1;
    end
    return start;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] sta_a, sta_b, sta_c, sta_z, sta_d, bcast, grp, sta_x, sta_y;
    int cyc;
    sta_a = 48'h02_11_22_33_44_01;
    sta_b = 48'h02_11_22_33_44_02;
    sta_c = 48'h02_55_66_77_88_03;
    sta_z = 48'h02_99_00_00_00_07;
    sta_d = 48'h02_AB_CD_00_00_09;
    bcast = 48'hFF_FF_FF_FF_FF_FF;
    grp   = 48'h01_00_5E_00_00_10;
    sta_x = twin(grp,   48'h06_00_00_00_10_00);
    sta_y = twin(sta_b, 48'h0A_00_00_00_20_00);
    for (int e = 0; e < DEPTH; e++) m_v[e] = 1'b0;

    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    req_dst = '0; req_src = '0; req_port = '0; req_dev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: offer a frame during the sweep; it must not be taken
    req_dst = sta_a; req_src = sta_z; req_port = 3'd0; req_dev = '0;
    req_valid = 1'b1;
    chk("R1", "busy after reset", longint'(busy), 1);
    cyc = 0;
    while (busy && cyc < 1000) begin
      if (req_ready) chk("R1", "ready while busy", longint'(req_ready), 0);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    checks++;
    if (cyc < DEPTH || cyc > DEPTH + 4) begin
      errors++;
      $display("FAIL R1 clear length actual=%0d expected=%0d..%0d", cyc, DEPTH, DEPTH + 4);
    end
    @(negedge clk);
    chk("R1", "no response from refused frame", longint'(rsp_valid), 0);

    // R1/R5: refused source Z never learned, empty table floods
    frame(sta_z, sta_a, 1, 0, 1'b0, "R1");
    frame(sta_b, sta_a, 1, 0, 1'b0, "R5");
    // R3/R4: learn B on port 4 device 2, then direct to A and back
    frame(sta_a, sta_b, 4, 2, 1'b0, "R4");
    frame(sta_b, sta_a, 1, 0, 1'b0, "R3");
    // R6: broadcast and group destinations flood even when table full-ish
    frame(bcast, sta_c, 3, 1, 1'b0, "R6");
    frame(grp,   sta_c, 3, 1, 1'b0, "R6");
    // R7: group source sharing X's index must not evict X
    frame(sta_a, sta_x, 5, 3, 1'b0, "R3");
    frame(sta_a, grp,   2, 1, 1'b0, "R7");
    frame(sta_x, sta_c, 3, 1, 1'b0, "R7");
    // R8: A moves to port 6, device 1
    frame(sta_c, sta_a, 6, 1, 1'b0, "R8");
    frame(sta_a, sta_b, 4, 2, 1'b0, "R8");
    // R9: destination on ingress port is filtered
    frame(sta_a, sta_c, 6, 1, 1'b0, "R9");
    // R10: own-source destination sees table before learning
    frame(sta_d, sta_d, 2, 0, 1'b0, "R10");
    frame(sta_d, sta_a, 6, 1, 1'b0, "R10");
    // R2/R10: hash twin of B evicts B
    frame(sta_b, sta_y, 7, 3, 1'b0, "R2");
    frame(sta_y, sta_a, 6, 1, 1'b0, "R10");
    // R11: stalled consumer
    frame(sta_y, sta_c, 0, 0, 1'b1, "R11");
    frame(sta_c, sta_y, 7, 3, 1'b1, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule